// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is the clocked front end of a single-port synchronous burst memory. On every rising clock edge it samples three chip selects, two address strobes, a burst advance input, a global write, a lane-write gate and one enable per byte lane. From these it classifies the cycle as one of the following:

- a blocked cycle (sleep or wake-up recovery);
- a deselect;
- the start of a new burst;
- a step to the next burst beat;
- a repeat of the current beat.

It then drives the burst address counter, the per-lane write strobes of a behavioural storage array, and the read-data direction control.

The two strobes follow different rules:

- **Processor-side strobe.** It counts only while the first select is active. It always opens a read burst.
- **Controller-side strobe.** It opens a burst whose direction follows the sampled write controls.

A sleep request overrides every other control. The power-down flag rises after two clock edges with sleep held high. After sleep is released, two further edges are ignored before accesses resume.

Top module: `burst_sram_ctrl`

## Requirements
- R1: Lane write mask: `wr_all_n`=0 writes every lane. Otherwise `wr_lane_gate_n`=0 writes exactly the lanes whose `lane_en_n` bit is 0 (bit i is the byte `wdata[8i+7:8i]`). With `wr_all_n`, `wr_lane_gate_n` and all `lane_en_n` bits at 1, the cycle is a read.
- R2: A strobe begins a burst only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Under any other select combination, a counted strobe gives a deselect: nothing is written, and `dq_oe` is 0 for the following cycle.
- R3: While `sel_a_n`=1, `strb_cpu_n` has no effect. A low `strb_ctl_n` in that state gives a deselect.
- R4: A burst opened by `strb_cpu_n`=0 (with `sel_a_n`=0) is always a read at `addr`, whatever the write controls show.
- R5: A burst opened by `strb_ctl_n`=0 (with `strb_cpu_n`=1 and the chip selected) is a write at `addr` if the R1 mask is non-zero, and otherwise a read.
- R6: With both strobes high, `burst_adv_n`=0 steps the address: its two low bits increase by one modulo 4, and the upper bits are kept. `burst_adv_n`=1 repeats the address. The cycle reads or writes per R1.
- R7: A read at edge k puts the word at the used address on `dq_out` from edge k to edge k+1. `dq_oe` is high only during such a read window while `out_en_n`=0 and `sleep_req`=0. It follows `out_en_n` without waiting for a clock, and is 0 after any write cycle.
- R8: At an edge where `sleep_req`=1, nothing is read or written and the counter keeps its value. `dq_oe` is 0 whenever `sleep_req` is 1.
- R9: `pwr_down` goes to 1 after the second consecutive edge with `sleep_req`=1 and returns to 0 at the first edge with `sleep_req`=0. That edge and the next one perform no access; the third edge is a normal cycle.
- R10: Deselect and blocked cycles keep the burst counter. A later step continues from the held address, and a new burst loads `addr`.
- R11: After reset, `dq_oe` and `pwr_down` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Sleep request, overrides all controls |
| sel_a_n | input | 1 | First chip select, active low |
| sel_b | input | 1 | Second chip select, active high |
| sel_c_n | input | 1 | Third chip select, active low |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| burst_adv_n | input | 1 | Burst step request, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_lane_gate_n | input | 1 | Lane-write gate, active low |
| lane_en_n | input | BYTES | Per-lane write enables, active low |
| out_en_n | input | 1 | Asynchronous read output enable, active low |
| addr | input | ADDR_W | External word address |
| wdata | input | BYTES*LANE_W | Write data |
| dq_out | output | BYTES*LANE_W | Read data |
| dq_oe | output | 1 | Data bus drive enable |
| pwr_down | output | 1 | Power-down state flag |

## Verification
The bench uses the default parameters: 8 address bits, 2 burst bits, 2 lanes of 8 bits. At this size the whole 256-word array can be filled through the normal write path before checking starts, so every later read has a known expected word. Two lanes give partial writes in which one byte changes and the other survives. A 4-beat block means random step sequences cross the wrap point many times. Directed cases cover sleep entry and recovery timing, the asynchronous output enable, the ignored processor strobe, and continuing a burst from a counter held over a deselect.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

  typedef enum logic [1:0] {
    PW_RUN   = 2'd0,
    PW_ENTER = 2'd1,
    PW_DOWN  = 2'd2,
    PW_WAKE  = 2'd3
  } pwr_state_e;

  typedef enum logic [2:0] {
    CY_BLOCK = 3'd0,
    CY_DESEL = 3'd1,
    CY_START = 3'd2,
    CY_NEXT  = 3'd3,
    CY_HOLD  = 3'd4
  } cyc_e;

endpackage

// File: rtl/sbsram_pwr.sv
module sbsram_pwr
  import sbsram_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  output logic acc_ok,
  output logic pwr_down
);

  pwr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      PW_RUN:   state_d = sleep_req ? PW_ENTER : PW_RUN;
      PW_ENTER: state_d = sleep_req ? PW_DOWN  : PW_RUN;
      PW_DOWN:  state_d = sleep_req ? PW_DOWN  : PW_WAKE;
      PW_WAKE:  state_d = sleep_req ? PW_ENTER : PW_RUN;
      default:  state_d = PW_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PW_RUN;
    else        state_q <= state_d;
  end

  always_comb begin
    acc_ok   = !sleep_req && (state_q != PW_DOWN) && (state_q != PW_WAKE);
    pwr_down = (state_q == PW_DOWN);
  end

  // R9: the flag rises only after two consecutive sampled sleep edges
  assert_down_after_two_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_down) |-> ($past(sleep_req) && $past(sleep_req, 2)));

  // R9: the edge right after leaving power-down is still a recovery edge
  assert_wake_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_down) |-> !acc_ok);

endmodule

// File: rtl/sbsram_cycle_dec.sv
module sbsram_cycle_dec
  import sbsram_pkg::*;
#(
  parameter int BYTES = 2
) (
  input  logic             acc_ok,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             strb_cpu_n,
  input  logic             strb_ctl_n,
  input  logic             burst_adv_n,
  input  logic             wr_all_n,
  input  logic             wr_lane_gate_n,
  input  logic [BYTES-1:0] lane_en_n,
  output cyc_e             cyc,
  output logic [BYTES-1:0] lane_we
);

  logic [BYTES-1:0] mask;
  logic             selected;

  always_comb begin
    mask = '0;
    if (!wr_all_n)            mask = '1;
    else if (!wr_lane_gate_n) mask = ~lane_en_n;
  end

  assign selected = !sel_a_n && sel_b && !sel_c_n;

  always_comb begin
    cyc     = CY_BLOCK;
    lane_we = '0;
    if (acc_ok) begin
      if (!sel_a_n && !strb_cpu_n) begin
        cyc = selected ? CY_START : CY_DESEL;
      end else if (!strb_ctl_n) begin
        cyc = selected ? CY_START : CY_DESEL;
        if (selected) lane_we = mask;
      end else begin
        cyc     = burst_adv_n ? CY_HOLD : CY_NEXT;
        lane_we = mask;
      end
    end
  end

endmodule

// File: rtl/sbsram_burst_cnt.sv
module sbsram_burst_cnt
  import sbsram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cyc_e              cyc,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] use_addr
);

  localparam int HI_W = ADDR_W - BURST_W;
  localparam logic [BURST_W-1:0] BEAT_STEP = BURST_W'(1);

  logic [ADDR_W-1:0]  cnt_q;
  logic [HI_W-1:0]    hi_q;
  logic [BURST_W-1:0] lo_q;
  logic               load_en;

  assign hi_q = cnt_q[ADDR_W-1:BURST_W];
  assign lo_q = cnt_q[BURST_W-1:0];

  always_comb begin
    case (cyc)
      CY_START: use_addr = ext_addr;
      CY_NEXT:  use_addr = {hi_q, lo_q + BEAT_STEP};
      default:  use_addr = cnt_q;
    endcase
  end

  assign load_en = (cyc == CY_START) || (cyc == CY_NEXT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (load_en) cnt_q <= use_addr;
  end

  // R6: a step wraps inside the block and keeps the upper bits
  assert_step_wraps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cyc) == CY_NEXT) |->
      (lo_q == $past(lo_q) + BEAT_STEP) && (hi_q == $past(hi_q)));

  // R10: idle cycles keep the counter
  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(cyc) == CY_DESEL || $past(cyc) == CY_BLOCK)) |->
      $stable(cnt_q));

endmodule

// File: rtl/sbsram_mem.sv
module sbsram_mem #(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic [BYTES-1:0]        lane_we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [BYTES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [BYTES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we[g]) store[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = store[raddr];
  end

endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import sbsram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2,
  parameter int BYTES   = 2,
  parameter int LANE_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sleep_req,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    strb_cpu_n,
  input  logic                    strb_ctl_n,
  input  logic                    burst_adv_n,
  input  logic                    wr_all_n,
  input  logic                    wr_lane_gate_n,
  input  logic [BYTES-1:0]        lane_en_n,
  input  logic                    out_en_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BYTES*LANE_W-1:0] wdata,
  output logic [BYTES*LANE_W-1:0] dq_out,
  output logic                    dq_oe,
  output logic                    pwr_down
);

  localparam int DATA_W = BYTES * LANE_W;

  logic              acc_ok;
  cyc_e              cyc;
  logic [BYTES-1:0]  lane_we;
  logic [ADDR_W-1:0] use_addr;
  logic              rd_act_d, rd_act_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [DATA_W-1:0] rdata;
  logic              sel_ok;

  sbsram_pwr u_pwr (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_req (sleep_req),
    .acc_ok    (acc_ok),
    .pwr_down  (pwr_down)
  );

  sbsram_cycle_dec #(.BYTES(BYTES)) u_dec (
    .acc_ok         (acc_ok),
    .sel_a_n        (sel_a_n),
    .sel_b          (sel_b),
    .sel_c_n        (sel_c_n),
    .strb_cpu_n     (strb_cpu_n),
    .strb_ctl_n     (strb_ctl_n),
    .burst_adv_n    (burst_adv_n),
    .wr_all_n       (wr_all_n),
    .wr_lane_gate_n (wr_lane_gate_n),
    .lane_en_n      (lane_en_n),
    .cyc            (cyc),
    .lane_we        (lane_we)
  );

  sbsram_burst_cnt #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc      (cyc),
    .ext_addr (addr),
    .use_addr (use_addr)
  );

  sbsram_mem #(.ADDR_W(ADDR_W), .BYTES(BYTES), .LANE_W(LANE_W)) u_mem (
    .clk     (clk),
    .lane_we (lane_we),
    .waddr   (use_addr),
    .wdata   (wdata),
    .raddr   (rd_addr_q),
    .rdata   (rdata)
  );

  always_comb begin
    rd_act_d = ((cyc == CY_START) || (cyc == CY_NEXT) || (cyc == CY_HOLD))
               && (lane_we == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act_q  <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      rd_act_q <= rd_act_d;
      if (rd_act_d) rd_addr_q <= use_addr;
    end
  end

  assign dq_out = rdata;
  assign dq_oe  = rd_act_q && !out_en_n && !sleep_req;
  assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

  // R4: the processor strobe never opens a write
  assert_cpu_strobe_reads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && !sel_a_n && !strb_cpu_n) |-> (lane_we == '0));

  // R2: a counted strobe without full selection leaves the bus idle
  assert_desel_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && !sel_ok && (!strb_ctl_n || (!sel_a_n && !strb_cpu_n))) |=>
      !rd_act_q);

  // R8: a sleep edge performs no write and opens no read window
  assert_sleep_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> (lane_we == '0));
  assert_sleep_no_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> !rd_act_q);

  // R7: the bus never drives after a write edge
  assert_write_masks_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(lane_we) != '0) |-> !dq_oe);

endmodule

// File: tb/burst_sram_ctrl_tb.sv
`timescale 1ns/1ps
module burst_sram_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep_req = 1'b0;
  logic        sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0;
  logic        strb_cpu_n = 1'b1, strb_ctl_n = 1'b1, burst_adv_n = 1'b1;
  logic        wr_all_n = 1'b1, wr_lane_gate_n = 1'b1;
  logic [1:0]  lane_en_n = 2'b11;
  logic        out_en_n = 1'b0;
  logic [7:0]  addr = 8'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] dq_out;
  logic        dq_oe, pwr_down;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  burst_sram_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .burst_adv_n(burst_adv_n),
    .wr_all_n(wr_all_n), .wr_lane_gate_n(wr_lane_gate_n), .lane_en_n(lane_en_n),
    .out_en_n(out_en_n), .addr(addr), .wdata(wdata),
    .dq_out(dq_out), .dq_oe(dq_oe), .pwr_down(pwr_down)
  );

  // reference model built from the requirements
  logic [15:0] m_mem [256];
  logic [7:0]  m_cnt = 8'd0;
  logic [7:0]  m_rda = 8'd0;
  logic        m_rd = 1'b0;
  int          m_st = 0;
  string       m_tag = "R11";

  function automatic logic [1:0] ref_mask(logic g, logic b, logic [1:0] e);
    if (!g)      return 2'b11;
    else if (!b) return ~e;
    else         return 2'b00;
  endfunction

  function automatic int ref_next_state(int s, logic slp);
    case (s)
      0:       return slp ? 1 : 0;
      1:       return slp ? 2 : 0;
      2:       return slp ? 2 : 3;
      default: return slp ? 1 : 0;
    endcase
  endfunction

  task automatic ref_rw(input logic [1:0] msk, input string rd_tag);
    if (msk != 2'b00) begin
      if (msk[0]) m_mem[m_cnt][7:0]  = wdata[7:0];
      if (msk[1]) m_mem[m_cnt][15:8] = wdata[15:8];
      m_rd  = 1'b0;
      m_tag = "R1";
    end else begin
      m_rd  = 1'b1;
      m_rda = m_cnt;
      m_tag = rd_tag;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_rd = 1'b0; m_cnt = 8'd0; m_rda = 8'd0; m_tag = "R11";
    end else begin
      logic [1:0] msk;
      logic       sel;
      msk = ref_mask(wr_all_n, wr_lane_gate_n, lane_en_n);
      sel = !sel_a_n && sel_b && !sel_c_n;
      if (sleep_req || m_st == 2 || m_st == 3) begin
        m_rd  = 1'b0;
        m_tag = sleep_req ? "R8" : "R9";
      end else if (!sel_a_n && !strb_cpu_n) begin
        if (sel) begin m_cnt = addr; m_rd = 1'b1; m_rda = addr; m_tag = "R4"; end
        else begin m_rd = 1'b0; m_tag = "R2"; end
      end else if (!strb_ctl_n) begin
        if (sel) begin m_cnt = addr; ref_rw(msk, "R5"); end
        else begin m_rd = 1'b0; m_tag = (sel_a_n && !strb_cpu_n) ? "R3" : "R2"; end
      end else begin
        if (!burst_adv_n) m_cnt = {m_cnt[7:2], m_cnt[1:0] + 2'd1};
        ref_rw(msk, "R6");
      end
      m_st = ref_next_state(m_st, sleep_req);
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    logic exp_oe;
    @(posedge clk);
    @(negedge clk);
    exp_oe = m_rd && !out_en_n && !sleep_req;
    check({m_tag, " bus enable"}, 32'(dq_oe), 32'(exp_oe));
    if (exp_oe) check({m_tag, " read data"}, 32'(dq_out), 32'(m_mem[m_rda]));
    check("R9 power-down flag", 32'(pwr_down), 32'(m_st == 2));
  endtask

  task automatic set_idle();
    sleep_req = 1'b0; sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    strb_cpu_n = 1'b1; strb_ctl_n = 1'b1; burst_adv_n = 1'b1;
    wr_all_n = 1'b1; wr_lane_gate_n = 1'b1; lane_en_n = 2'b11; out_en_n = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R11 actual=%0h expected=%0h", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [15:0] old;
    r = $urandom(32'd20817);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R11 reset bus enable", 32'(dq_oe), 32'd0);
    check("R11 reset power-down", 32'(pwr_down), 32'd0);

    // fill every word through controller-strobe writes (R5)
    for (int a = 0; a < 256; a++) begin
      set_idle();
      strb_ctl_n = 1'b0; wr_all_n = 1'b0; addr = 8'(a);
      r = $urandom; wdata = r[15:0];
      step();
    end

    // R4: processor strobe with write controls active still reads
    set_idle();
    strb_cpu_n = 1'b0; wr_all_n = 1'b0; addr = 8'h05; wdata = 16'h1234;
    step();
    check("R4 cpu strobe read data", 32'(dq_out), 32'(m_mem[8'h05]));
    check("R4 cpu strobe drives", 32'(dq_oe), 32'd1);

    // R7: output enable acts between edges
    out_en_n = 1'b1; #1;
    check("R7 async disable", 32'(dq_oe), 32'd0);
    out_en_n = 1'b0; #1;
    check("R7 async enable", 32'(dq_oe), 32'd1);

    // R10 and R6: held counter across a deselect, then wrap 3 -> 0
    set_idle(); strb_cpu_n = 1'b0; addr = 8'h13; step();
    set_idle(); sel_b = 1'b0; strb_ctl_n = 1'b0; addr = 8'h77; step();
    check("R2 deselect bus idle", 32'(dq_oe), 32'd0);
    set_idle(); burst_adv_n = 1'b0; step();
    check("R10 step from held address", 32'(dq_out), 32'(m_mem[8'h10]));
    check("R6 wrap drives", 32'(dq_oe), 32'd1);

    // R3: first select high, processor strobe ignored, controller strobe deselects
    set_idle(); sel_a_n = 1'b1; strb_cpu_n = 1'b0; strb_ctl_n = 1'b0; step();
    check("R3 deselect", 32'(dq_oe), 32'd0);

    // R9 and R8: sleep entry, recovery with write attempts
    old = m_mem[8'h20];
    set_idle(); sleep_req = 1'b1; step();
    check("R9 one sleep edge", 32'(pwr_down), 32'd0);
    check("R8 sleep tristate", 32'(dq_oe), 32'd0);
    step();
    check("R9 two sleep edges", 32'(pwr_down), 32'd1);
    set_idle(); strb_ctl_n = 1'b0; wr_all_n = 1'b0; addr = 8'h20; wdata = ~old;
    step();
    check("R9 recovery edge one", 32'(pwr_down), 32'd0);
    step();
    set_idle(); strb_cpu_n = 1'b0; addr = 8'h20; step();
    check("R9 recovery writes ignored", 32'(dq_out), 32'(old));

    // R1: single-lane write through the lane gate
    set_idle(); strb_ctl_n = 1'b0; wr_lane_gate_n = 1'b0; lane_en_n = 2'b10;
    addr = 8'h20; wdata = 16'hABCD; step();
    set_idle(); strb_cpu_n = 1'b0; addr = 8'h20; step();
    check("R1 lane zero only", 32'(dq_out), 32'({old[15:8], 8'hCD}));

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      r = $urandom;
      sel_a_n     = (r[2:0] == 3'd0);
      sel_b       = (r[5:3] != 3'd0);
      sel_c_n     = (r[8:6] == 3'd0);
      strb_cpu_n  = (r[11:9] != 3'd0);
      strb_ctl_n  = (r[14:12] > 3'd1);
      burst_adv_n = r[15];
      wr_all_n    = (r[17:16] != 2'd0);
      wr_lane_gate_n = r[18];
      lane_en_n   = r[20:19];
      out_en_n    = (r[23:21] == 3'd0);
      sleep_req   = (r[29:24] < 6'd2);
      r = $urandom;
      addr = r[7:0]; wdata = r[23:8];
      step();
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule